// File: doc/BRIEF.md
# Deferred Line-Configuration Shadow Registers

This block sits between a host and the line-configuration registers of an asynchronous serial channel. The host never writes the live registers directly. It writes four shadow registers: mode, port value, data format and a 10-bit baud divisor. It can also set three single-bit controls: request-to-send, data-terminal-ready and transmit break. Each of these writes goes only into the shadows and raises one pending flag.

The shadows are copied to the live registers only while the transmitter reports that it is idle. All four are copied in the same clock cycle. A character that is being serialized therefore never sees its format, divisor or control lines change part way through.

The serializer and baud generator are not part of this block. They read the live outputs and drive the idle input. The upper two divisor bits are packed into the top of a second control register. The remaining low bits of that register are written directly by the host and are kept unchanged by every commit.

Top module: `line_cfg_shadow`

## Requirements
- R1: After reset every live output equals its reset parameter value, and `cfgPending` is 0.
- R2: A deferred write (mode, port, format, divisor, modem-control or break) made while `txIdle` is 0 leaves every deferred live output unchanged, and sets `cfgPending` to 1 on the next edge.
- R3: On the first edge where `txIdle` is 1 and `cfgPending` is 1, all four shadow values appear on the live outputs together, and `cfgPending` returns to 0.
- R4: A deferred write made while `txIdle` is 1 reaches the live outputs on that same edge, and `cfgPending` stays 0.
- R5: The divisor's bits 7:0 drive `liveDivLo`, and its bits 9:8 drive `liveCtl2[7:6]`.
- R6: `liveCtl2[5:0]` takes `ctl2WrData` on the edge where `ctl2WrEn` is 1, whatever the state of `txIdle`. No commit ever changes these bits.
- R7: A break request sets format bit 6 when `brkOn` is 1 and clears it when `brkOn` is 0. Like any other deferred write, it reaches the live outputs only while the transmitter is idle.
- R8: A modem-control write with `rtsOn`=1 clears mode bit 2 (force) and sets mode bit 1 (RTS). A write with `rtsOn`=0 sets both bits.
- R9: Port bit 0 is the active-low DTR bit. A modem-control write stores `!dtrOn` there.
- R10: A deferred write made in the same cycle as a commit is included in that commit. It is never lost.
- R11: When a whole-register write and a bit-level control write (modem-control or break) hit the same register in one cycle, the control bits take the value of the bit-level write.
- R12: Repeated writes to one shadow while the transmitter is busy keep only the last value, and that value is what commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txIdle | input | 1 | Transmitter idle / ready for data |
| modeWrEn | input | 1 | Mode shadow write strobe |
| modeWrData | input | 8 | Mode shadow write value |
| portWrEn | input | 1 | Port shadow write strobe |
| portWrData | input | 8 | Port shadow write value |
| fmtWrEn | input | 1 | Format shadow write strobe |
| fmtWrData | input | 8 | Format shadow write value |
| divWrEn | input | 1 | Divisor shadow write strobe |
| divWrData | input | 10 | Divisor shadow write value |
| mctrlWrEn | input | 1 | Modem-control write strobe |
| rtsOn | input | 1 | 1 = assert RTS |
| dtrOn | input | 1 | 1 = assert DTR |
| brkWrEn | input | 1 | Break control write strobe |
| brkOn | input | 1 | 1 = send break |
| ctl2WrEn | input | 1 | Immediate write of control-2 low bits |
| ctl2WrData | input | 6 | Control-2 low bits value |
| liveMode | output | 8 | Live mode register |
| livePort | output | 8 | Live port value register |
| liveFmt | output | 8 | Live data format register |
| liveDivLo | output | 8 | Live divisor bits 7:0 |
| liveCtl2 | output | 8 | Live control-2: divisor 9:8 in 7:6, host bits in 5:0 |
| cfgPending | output | 1 | Shadow differs from live, awaiting idle |

## Verification
The bench builds the block with its default widths: 8-bit registers, a 10-bit divisor split 8/2, and the control bits at mode 2/1, port 0 and format 6. It uses its own reset values so that every control bit starts from a known level.

At these sizes the whole divisor range fits in the run. All 1024 divisor values are committed and checked against their split. All four RTS/DTR combinations and both break levels are driven through busy-then-idle sequences.

Writes that coincide with commits, and bit-level writes that overlap whole-register writes, are also reached. Every register is compared on every cycle.

// File: rtl/lcfg_pkg.sv
package lcfg_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic commit;  // copy shadows to live this edge
    logic hold;    // a write landed while busy
  } lcfg_strobe_t;
endpackage

// File: rtl/lcfg_ctrl.sv
module lcfg_ctrl
  import lcfg_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         txIdle,
  input  logic         anyWrite,
  output lcfg_strobe_t strb,
  output logic         pending
);
  always_comb begin
    strb.commit = txIdle && (pending || anyWrite);
    strb.hold   = anyWrite && !txIdle;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           pending <= 1'b0;
    else if (strb.commit) pending <= 1'b0;
    else if (strb.hold)   pending <= 1'b1;
  end

  p_idle_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txIdle |=> !pending);
  p_busy_write_pends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (anyWrite && !txIdle) |=> pending);
  p_pending_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !txIdle) |=> pending);
endmodule

// File: rtl/lcfg_dpath.sv
module lcfg_dpath
  import lcfg_pkg::*;
#(
  parameter int REG_W      = 8,
  parameter int DIV_W      = 10,
  parameter int DIV_LO_W   = 8,
  parameter int CTL_W      = 8,
  parameter int FRTS_BIT   = 2,
  parameter int RTS_BIT    = 1,
  parameter int DTR_BIT    = 0,
  parameter int BRK_BIT    = 6,
  parameter logic [REG_W-1:0] MODE_RST = '0,
  parameter logic [REG_W-1:0] PORT_RST = '0,
  parameter logic [REG_W-1:0] FMT_RST  = '0,
  parameter logic [DIV_W-1:0] DIV_RST  = '0,
  parameter logic [CTL_W-(DIV_W-DIV_LO_W)-1:0] CTL_LO_RST = '0,
  localparam int DIV_HI_W = DIV_W - DIV_LO_W,
  localparam int CTL_LO_W = CTL_W - DIV_HI_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  lcfg_strobe_t        strb,
  input  logic                modeWrEn,
  input  logic [REG_W-1:0]    modeWrData,
  input  logic                portWrEn,
  input  logic [REG_W-1:0]    portWrData,
  input  logic                fmtWrEn,
  input  logic [REG_W-1:0]    fmtWrData,
  input  logic                divWrEn,
  input  logic [DIV_W-1:0]    divWrData,
  input  logic                mctrlWrEn,
  input  logic                rtsOn,
  input  logic                dtrOn,
  input  logic                brkWrEn,
  input  logic                brkOn,
  input  logic                ctl2WrEn,
  input  logic [CTL_LO_W-1:0] ctl2WrData,
  output logic                anyWrite,
  output logic [REG_W-1:0]    liveMode,
  output logic [REG_W-1:0]    livePort,
  output logic [REG_W-1:0]    liveFmt,
  output logic [DIV_LO_W-1:0] liveDivLo,
  output logic [CTL_W-1:0]    liveCtl2
);
  logic [REG_W-1:0]    shMode, shPort, shFmt;
  logic [DIV_W-1:0]    shDiv;
  logic [REG_W-1:0]    nxMode, nxPort, nxFmt;
  logic [DIV_W-1:0]    nxDiv;
  logic [DIV_HI_W-1:0] liveDivHi;
  logic [CTL_LO_W-1:0] ctlLo;

  assign anyWrite = modeWrEn | portWrEn | fmtWrEn | divWrEn | mctrlWrEn | brkWrEn;

  // Next shadow values: whole-register write first, then bit-level overrides
  always_comb begin
    nxMode = modeWrEn ? modeWrData : shMode;
    nxPort = portWrEn ? portWrData : shPort;
    nxFmt  = fmtWrEn  ? fmtWrData  : shFmt;
    nxDiv  = divWrEn  ? divWrData  : shDiv;
    if (mctrlWrEn) begin
      nxMode[FRTS_BIT] = !rtsOn;
      nxMode[RTS_BIT]  = 1'b1;
      nxPort[DTR_BIT]  = !dtrOn;
    end
    if (brkWrEn) nxFmt[BRK_BIT] = brkOn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shMode <= MODE_RST;
      shPort <= PORT_RST;
      shFmt  <= FMT_RST;
      shDiv  <= DIV_RST;
    end else begin
      shMode <= nxMode;
      shPort <= nxPort;
      shFmt  <= nxFmt;
      shDiv  <= nxDiv;
    end
  end

  // Live registers: the commit takes the next-shadow values, so a write in
  // the commit cycle is included
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      liveMode  <= MODE_RST;
      livePort  <= PORT_RST;
      liveFmt   <= FMT_RST;
      liveDivLo <= DIV_RST[DIV_LO_W-1:0];
      liveDivHi <= DIV_RST[DIV_W-1:DIV_LO_W];
    end else if (strb.commit) begin
      liveMode  <= nxMode;
      livePort  <= nxPort;
      liveFmt   <= nxFmt;
      liveDivLo <= nxDiv[DIV_LO_W-1:0];
      liveDivHi <= nxDiv[DIV_W-1:DIV_LO_W];
    end
  end

  // Host-owned low bits of control-2 are written directly
  always_ff @(posedge clk) begin
    if (!rst_n)        ctlLo <= CTL_LO_RST;
    else if (ctl2WrEn) ctlLo <= ctl2WrData;
  end

  assign liveCtl2 = {liveDivHi, ctlLo};

  p_commit_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.commit |=> (liveMode == shMode) && (livePort == shPort) &&
                    (liveFmt == shFmt) && ({liveDivHi, liveDivLo} == shDiv));
  p_rts_encoding_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mctrlWrEn |=> shMode[RTS_BIT] && (shMode[FRTS_BIT] == !$past(rtsOn)));
endmodule

// File: rtl/line_cfg_shadow.sv
module line_cfg_shadow
  import lcfg_pkg::*;
#(
  parameter int REG_W      = 8,
  parameter int DIV_W      = 10,
  parameter int DIV_LO_W   = 8,
  parameter int CTL_W      = 8,
  parameter int FRTS_BIT   = 2,
  parameter int RTS_BIT    = 1,
  parameter int DTR_BIT    = 0,
  parameter int BRK_BIT    = 6,
  parameter logic [REG_W-1:0] MODE_RST = 8'h06,
  parameter logic [REG_W-1:0] PORT_RST = 8'h01,
  parameter logic [REG_W-1:0] FMT_RST  = 8'h03,
  parameter logic [DIV_W-1:0] DIV_RST  = 10'd11,
  parameter logic [CTL_W-(DIV_W-DIV_LO_W)-1:0] CTL_LO_RST = '0,
  localparam int DIV_HI_W = DIV_W - DIV_LO_W,
  localparam int CTL_LO_W = CTL_W - DIV_HI_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                txIdle,
  input  logic                modeWrEn,
  input  logic [REG_W-1:0]    modeWrData,
  input  logic                portWrEn,
  input  logic [REG_W-1:0]    portWrData,
  input  logic                fmtWrEn,
  input  logic [REG_W-1:0]    fmtWrData,
  input  logic                divWrEn,
  input  logic [DIV_W-1:0]    divWrData,
  input  logic                mctrlWrEn,
  input  logic                rtsOn,
  input  logic                dtrOn,
  input  logic                brkWrEn,
  input  logic                brkOn,
  input  logic                ctl2WrEn,
  input  logic [CTL_LO_W-1:0] ctl2WrData,
  output logic [REG_W-1:0]    liveMode,
  output logic [REG_W-1:0]    livePort,
  output logic [REG_W-1:0]    liveFmt,
  output logic [DIV_LO_W-1:0] liveDivLo,
  output logic [CTL_W-1:0]    liveCtl2,
  output logic                cfgPending
);
  lcfg_strobe_t strb;
  logic         anyWrite;

  lcfg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .txIdle(txIdle), .anyWrite(anyWrite),
    .strb(strb), .pending(cfgPending)
  );

  lcfg_dpath #(
    .REG_W(REG_W), .DIV_W(DIV_W), .DIV_LO_W(DIV_LO_W), .CTL_W(CTL_W),
    .FRTS_BIT(FRTS_BIT), .RTS_BIT(RTS_BIT), .DTR_BIT(DTR_BIT), .BRK_BIT(BRK_BIT),
    .MODE_RST(MODE_RST), .PORT_RST(PORT_RST), .FMT_RST(FMT_RST),
    .DIV_RST(DIV_RST), .CTL_LO_RST(CTL_LO_RST)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .portWrEn(portWrEn), .portWrData(portWrData),
    .fmtWrEn(fmtWrEn), .fmtWrData(fmtWrData),
    .divWrEn(divWrEn), .divWrData(divWrData),
    .mctrlWrEn(mctrlWrEn), .rtsOn(rtsOn), .dtrOn(dtrOn),
    .brkWrEn(brkWrEn), .brkOn(brkOn),
    .ctl2WrEn(ctl2WrEn), .ctl2WrData(ctl2WrData),
    .anyWrite(anyWrite),
    .liveMode(liveMode), .livePort(livePort), .liveFmt(liveFmt),
    .liveDivLo(liveDivLo), .liveCtl2(liveCtl2)
  );

  p_busy_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !txIdle |=> $stable(liveMode) && $stable(livePort) && $stable(liveFmt) &&
                $stable(liveDivLo) && $stable(liveCtl2[CTL_W-1:CTL_LO_W]));
  p_ctl2_low_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl2WrEn |=> $stable(liveCtl2[CTL_LO_W-1:0]));
  p_idle_write_no_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (txIdle && anyWrite) |=> !cfgPending);
endmodule

// File: tb/line_cfg_shadow_test.sv
`timescale 1ns/1ps
module line_cfg_shadow_test;
  localparam logic [7:0] M_RST = 8'h06;
  localparam logic [7:0] P_RST = 8'h01;
  localparam logic [7:0] F_RST = 8'h03;
  localparam logic [9:0] D_RST = 10'd11;
  localparam logic [5:0] C_RST = 6'h15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txIdle = 1'b0;
  logic modeWrEn = 0, portWrEn = 0, fmtWrEn = 0, divWrEn = 0;
  logic mctrlWrEn = 0, brkWrEn = 0, ctl2WrEn = 0;
  logic rtsOn = 0, dtrOn = 0, brkOn = 0;
  logic [7:0] modeWrData = 0, portWrData = 0, fmtWrData = 0;
  logic [9:0] divWrData = 0;
  logic [5:0] ctl2WrData = 0;
  logic [7:0] liveMode, livePort, liveFmt, liveDivLo, liveCtl2;
  logic cfgPending;

  int total = 0;
  int bad = 0;

  // Expected model, built from the requirements
  logic [7:0] eMode, ePort, eFmt, eLMode, eLPort, eLFmt;
  logic [9:0] eDiv, eLDiv;
  logic [5:0] eCtl;
  logic ePend;

  always #2 clk = ~clk;

  line_cfg_shadow #(.CTL_LO_RST(C_RST)) uut (
    .clk(clk), .rst_n(rst_n), .txIdle(txIdle),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData),
    .portWrEn(portWrEn), .portWrData(portWrData),
    .fmtWrEn(fmtWrEn), .fmtWrData(fmtWrData),
    .divWrEn(divWrEn), .divWrData(divWrData),
    .mctrlWrEn(mctrlWrEn), .rtsOn(rtsOn), .dtrOn(dtrOn),
    .brkWrEn(brkWrEn), .brkOn(brkOn),
    .ctl2WrEn(ctl2WrEn), .ctl2WrData(ctl2WrData),
    .liveMode(liveMode), .livePort(livePort), .liveFmt(liveFmt),
    .liveDivLo(liveDivLo), .liveCtl2(liveCtl2), .cfgPending(cfgPending)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk({tag, " mode"}, liveMode, eLMode);
    chk({tag, " port"}, livePort, eLPort);
    chk({tag, " fmt"}, liveFmt, eLFmt);
    chk({tag, " divlo"}, liveDivLo, eLDiv[7:0]);
    chk({tag, " ctl2"}, liveCtl2, {eLDiv[9:8], eCtl});
    chk({tag, " pend"}, cfgPending, ePend);
  endtask

  // One clock: model the edge from the current inputs, then drop strobes
  task automatic tick();
    logic [7:0] nM, nP, nF;
    logic [9:0] nD;
    logic anyW, com;
    nM = modeWrEn ? modeWrData : eMode;
    nP = portWrEn ? portWrData : ePort;
    nF = fmtWrEn ? fmtWrData : eFmt;
    nD = divWrEn ? divWrData : eDiv;
    if (mctrlWrEn) begin
      nM[2] = !rtsOn;  // R8 force bit
      nM[1] = 1'b1;    // R8 RTS bit
      nP[0] = !dtrOn;  // R9 active-low DTR
    end
    if (brkWrEn) nF[6] = brkOn;  // R7
    anyW = modeWrEn | portWrEn | fmtWrEn | divWrEn | mctrlWrEn | brkWrEn;
    com = txIdle && (ePend || anyW);
    if (ctl2WrEn) eCtl = ctl2WrData;
    eMode = nM; ePort = nP; eFmt = nF; eDiv = nD;
    if (com) begin
      eLMode = nM; eLPort = nP; eLFmt = nF; eLDiv = nD; ePend = 1'b0;
    end else if (anyW) ePend = 1'b1;
    @(negedge clk);
    modeWrEn = 0; portWrEn = 0; fmtWrEn = 0; divWrEn = 0;
    mctrlWrEn = 0; brkWrEn = 0; ctl2WrEn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    eMode = M_RST; ePort = P_RST; eFmt = F_RST; eDiv = D_RST;
    eLMode = M_RST; eLPort = P_RST; eLFmt = F_RST; eLDiv = D_RST;
    eCtl = C_RST; ePend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    checkAll("R1 reset");

    // R2 / R12: busy writes, last one wins
    txIdle = 0;
    modeWrEn = 1; modeWrData = 8'hA5; tick(); checkAll("R2 busy mode");
    portWrEn = 1; portWrData = 8'h3C; tick(); checkAll("R2 busy port");
    fmtWrEn = 1; fmtWrData = 8'h11; tick(); checkAll("R2 busy fmt");
    divWrEn = 1; divWrData = 10'h2F0; tick(); checkAll("R12 div first");
    divWrEn = 1; divWrData = 10'h1C3; tick(); checkAll("R12 div second");
    tick(); checkAll("R2 busy hold");
    // R3: commit on idle
    txIdle = 1; tick(); checkAll("R3 commit");
    chk("R12 committed div", {liveCtl2[7:6], liveDivLo}, 10'h1C3);
    tick(); checkAll("R3 idle quiet");

    // R4: write while idle lands at once
    modeWrEn = 1; modeWrData = 8'h5A; tick(); checkAll("R4 idle write");

    // R5: every divisor value while idle
    for (int d = 0; d < 1024; d++) begin
      divWrEn = 1; divWrData = d[9:0]; tick();
      chk("R5 divlo", liveDivLo, d & 8'hFF);
      chk("R5 divhi", liveCtl2[7:6], d >> 8);
    end
    checkAll("R5 sweep end");

    // R6: ctl2 low bits immediate, untouched by commits
    txIdle = 0;
    ctl2WrEn = 1; ctl2WrData = 6'h2A; divWrEn = 1; divWrData = 10'h3FF;
    tick(); checkAll("R6 busy ctl2");
    txIdle = 1; tick(); checkAll("R6 commit keeps low");
    ctl2WrEn = 1; ctl2WrData = 6'h01; tick(); checkAll("R6 idle ctl2");

    // R7: break on/off, deferred
    for (int b = 0; b < 2; b++) begin
      txIdle = 0; brkWrEn = 1; brkOn = b[0]; tick(); checkAll("R7 break busy");
      chk("R7 fmt bit held", liveFmt[6], eLFmt[6]);
      txIdle = 1; tick(); checkAll("R7 break commit");
      chk("R7 fmt bit", liveFmt[6], b[0]);
    end

    // R8 / R9: all RTS/DTR combos
    for (int c = 0; c < 4; c++) begin
      txIdle = 0; mctrlWrEn = 1; rtsOn = c[0]; dtrOn = c[1]; tick();
      checkAll("R8 mctrl busy");
      txIdle = 1; tick(); checkAll("R8 mctrl commit");
      chk("R8 rts bits", liveMode[2:1], c[0] ? 2'b01 : 2'b11);
      chk("R9 dtr bit", livePort[0], !c[1]);
    end

    // R10: write in the same cycle as a pending commit
    txIdle = 0; portWrEn = 1; portWrData = 8'h44; tick(); checkAll("R10 pend");
    txIdle = 1; fmtWrEn = 1; fmtWrData = 8'h77; tick(); checkAll("R10 merged");
    chk("R10 fmt", liveFmt, 8'h77);
    chk("R10 port", livePort, 8'h44);

    // R11: bit-level overrides on top of whole-register writes
    txIdle = 0;
    modeWrEn = 1; modeWrData = 8'h00; mctrlWrEn = 1; rtsOn = 0; dtrOn = 1;
    portWrEn = 1; portWrData = 8'hFF; fmtWrEn = 1; fmtWrData = 8'h00;
    brkWrEn = 1; brkOn = 1; tick(); checkAll("R11 busy");
    txIdle = 1; tick(); checkAll("R11 commit");
    chk("R11 mode", liveMode, 8'h06);
    chk("R11 port", livePort, 8'hFE);
    chk("R11 fmt", liveFmt, 8'h40);

    // R1 again: reset restores everything
    rst_n = 0; tick();
    eMode = M_RST; ePort = P_RST; eFmt = F_RST; eDiv = D_RST;
    eLMode = M_RST; eLPort = P_RST; eLFmt = F_RST; eLDiv = D_RST;
    eCtl = C_RST; ePend = 0;
    checkAll("R1 re-reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule